// File: doc/BRIEF.md
# Ones-Density Violation Monitor

This block watches a received serial line one bit at a time and flags the moments when the stream carries too few ones to be healthy. Two rules are applied to every accepted bit. The first rule limits how many zeros may arrive in an unbroken row. The second rule requires a minimum count of ones inside a window of fixed length, and that window slides forward by one bit on each accepted bit, so every window position is judged.

Bits arrive on a valid/ready input. The block never applies back-pressure: `in_ready` is low only while reset is asserted and stays high after that, so a bit is taken on every clock edge where `in_valid` and `in_ready` are both high. A cycle with `in_valid` low carries no bit, and `in_bit` is ignored in that cycle. A rule violation sets a sticky status flag. The interrupt request is that flag gated by an enable pin. The host clears the flag with a one-cycle pulse on `status_clr`.

With the default parameters, a zero run longer than 15 is a violation, and so is a 192-bit window (8 × (23 + 1)) that holds fewer than 23 ones.

Top module: `pulse_density_mon`

## Requirements
- R1: `in_ready` is 0 while `rst_n` is low and 1 from the first clock edge after reset is released. A bit is accepted on every rising edge where `in_valid` and `in_ready` are both 1.
- R2: After reset, `density_status` and `density_irq` are both 0.
- R3: When the accepted bit is the 16th consecutive accepted zero (more than ZERO_LIMIT = 15), `density_status` is 1 from the edge that accepts it. A run of exactly 15 zeros causes no violation. Longer runs keep violating.
- R4: An accepted one ends the zero run. Cycles with `in_valid` low neither extend nor break the run, whatever `in_bit` carries.
- R5: Once at least 192 bits have been accepted, an accepted bit that completes a window of the latest 192 accepted bits holding fewer than 23 ones sets `density_status` from that edge. A window holding exactly 23 ones is not a violation.
- R6: While fewer than 192 bits have been accepted since reset, the window rule raises nothing.
- R7: `density_status` stays 1 until `status_clr` is high at an edge, after which it reads 0. If a violation is detected at that same edge, the set wins and the flag stays 1.
- R8: `density_irq` equals `density_status` AND `irq_en` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks `in_bit` as carrying a received bit |
| in_ready | output | 1 | High when a bit can be taken (always after reset) |
| in_bit | input | 1 | Received serial data bit |
| irq_en | input | 1 | Enables the interrupt request |
| status_clr | input | 1 | Clears the sticky density flag |
| density_status | output | 1 | Sticky flag, set by either density rule |
| density_irq | output | 1 | Interrupt request, the flag gated by `irq_en` |

## Verification
Each verdict for an accepted bit is registered on the edge that accepts the bit. `density_status` therefore shows the result one cycle after the bit is presented, and `density_irq` follows it with no extra delay. The bench drives every input on the falling edge and pushes one expected pair (status, irq) per cycle into a scoreboard queue. A monitor pops that entry 2 ns after the next rising edge, so each comparison lands exactly one register stage after its stimulus. The reference model keeps its own 192-bit history and zero-run count, and the stimulus covers runs of exactly 15 zeros, windows of exactly 23 ones, partial windows and idle gaps.

// File: rtl/pdm_pkg.sv
package pdm_pkg;
  // Cause of a density fault, one flag per rule.
  typedef struct packed {
    logic zero_run;
    logic sparse_window;
  } pdm_cause_t;

  function automatic logic any_cause(input pdm_cause_t c);
    return c.zero_run | c.sparse_window;
  endfunction
endpackage

// File: rtl/pdm_zero_run.sv
module pdm_zero_run #(
  parameter int ZERO_LIMIT = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic bit_in,
  output logic viol
);
  localparam int RUN_MAX = ZERO_LIMIT + 1;
  localparam int RW      = $clog2(RUN_MAX + 1);

  logic [RW-1:0] run_q;
  logic [RW-1:0] run_d;

  always_comb begin
    if (bit_in)                      run_d = '0;
    else if (run_q == RW'(RUN_MAX))  run_d = run_q;
    else                             run_d = run_q + 1'b1;
  end

  assign viol = accept && (run_d > RW'(ZERO_LIMIT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_q <= '0;
    else if (accept) run_q <= run_d;
  end

  AST_RUN_CLEARS_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && bit_in |=> run_q == '0);  // R4
  AST_RUN_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(run_q));  // R4
  AST_RUN_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(RUN_MAX));  // R3
endmodule

// File: rtl/pdm_window.sv
module pdm_window #(
  parameter int WIN_LEN  = 192,
  parameter int MIN_ONES = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic bit_in,
  output logic viol
);
  localparam int CW = $clog2(WIN_LEN + 1);

  logic [WIN_LEN-1:0] hist_q;
  logic [CW-1:0]      ones_q, ones_d;
  logic [CW-1:0]      fill_q, fill_d;
  logic               full_d;

  // Running count: the new bit enters, the oldest bit leaves.
  always_comb begin
    ones_d = ones_q + CW'(bit_in) - CW'(hist_q[WIN_LEN-1]);
    fill_d = (fill_q == CW'(WIN_LEN)) ? fill_q : fill_q + 1'b1;
    full_d = (fill_d == CW'(WIN_LEN));
  end

  assign viol = accept && full_d && (ones_d < CW'(MIN_ONES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      ones_q <= '0;
      fill_q <= '0;
    end else if (accept) begin
      hist_q <= {hist_q[WIN_LEN-2:0], bit_in};
      ones_q <= ones_d;
      fill_q <= fill_d;
    end
  end

  AST_FILL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= CW'(WIN_LEN));  // R6
  AST_ONES_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q <= fill_q);  // R5
  AST_NO_EARLY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q < CW'(WIN_LEN - 1)) |-> !viol);  // R6
endmodule

// File: rtl/pdm_status.sv
module pdm_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic status
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status <= 1'b0;
    else if (set) status <= 1'b1;
    else if (clr) status <= 1'b0;
  end

  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status && !clr |=> status);  // R7
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !status);  // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> status);  // R7
endmodule

// File: rtl/pulse_density_mon.sv
module pulse_density_mon #(
  parameter int ZERO_LIMIT = 15,
  parameter int MIN_ONES   = 23
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  input  logic irq_en,
  input  logic status_clr,
  output logic density_status,
  output logic density_irq
);
  import pdm_pkg::*;

  localparam int WIN_LEN = 8 * (MIN_ONES + 1);

  logic       accept;
  pdm_cause_t cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_ready <= 1'b0;
    else        in_ready <= 1'b1;
  end

  assign accept = in_valid && in_ready;

  pdm_zero_run #(.ZERO_LIMIT(ZERO_LIMIT)) u_zero_run (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .bit_in (in_bit),
    .viol   (cause.zero_run)
  );

  pdm_window #(.WIN_LEN(WIN_LEN), .MIN_ONES(MIN_ONES)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .bit_in (in_bit),
    .viol   (cause.sparse_window)
  );

  pdm_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (any_cause(cause)),
    .clr    (status_clr),
    .status (density_status)
  );

  assign density_irq = density_status & irq_en;

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);  // R1
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    density_irq |-> (irq_en && density_status));  // R8
  AST_IDLE_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> cause == '0);  // R4
endmodule

// File: tb/pulse_density_mon_bench.sv
module pulse_density_mon_bench;
  localparam int LIMIT = 15;
  localparam int MINO  = 23;
  localparam int WIN   = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, irq_en = 1'b0, status_clr = 1'b0;
  logic in_ready, density_status, density_irq;

  always #4 clk = ~clk;  // 125 MHz

  pulse_density_mon u_pulse_density_mon (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .irq_en(irq_en), .status_clr(status_clr),
    .density_status(density_status), .density_irq(density_irq)
  );

  typedef struct {
    bit    st;
    bit    irq;
    string tag;
  } exp_t;

  exp_t  sb[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;

  // Reference model state
  int    hq[$];
  int    zrun = 0;
  int    acc  = 0;
  bit    exp_st = 1'b0;
  string cur_tag = "R2";

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d (acc=%0d)", tag, what, act, expv, acc);
    end
  endtask

  // Driver: one cycle of stimulus plus the expected result after the next edge.
  task automatic drive(input bit v, input bit b, input bit en, input bit clr);
    bit viol;
    int ones;
    @(negedge clk);
    in_valid = v; in_bit = b; irq_en = en; status_clr = clr;
    viol = 1'b0;
    if (v) begin
      hq.push_back(int'(b));
      if (hq.size() > WIN) void'(hq.pop_front());
      acc++;
      zrun = b ? 0 : zrun + 1;
      ones = 0;
      foreach (hq[k]) ones += hq[k];
      viol = (zrun > LIMIT) || (acc >= WIN && ones < MINO);
    end
    exp_st = viol | (exp_st & ~clr);
    sb.push_back('{exp_st, exp_st & en, cur_tag});
  endtask

  // Monitor: compare 2 ns after each rising edge.
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check(density_status == e.st, e.tag, "status", int'(density_status), int'(e.st));
      check(density_irq == e.irq, "R8", "irq", int'(density_irq), int'(e.irq));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 / R2: state during reset
    repeat (3) @(posedge clk);
    #2;
    check(in_ready == 1'b0, "R1", "ready in reset", int'(in_ready), 0);
    check(density_status == 1'b0, "R2", "status in reset", int'(density_status), 0);
    check(density_irq == 1'b0, "R2", "irq in reset", int'(density_irq), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #2;
    check(in_ready == 1'b1, "R1", "ready after reset", int'(in_ready), 1);
    check(density_status == 1'b0, "R2", "status after reset", int'(density_status), 0);

    // R6: sparse but legal-run pattern while the window fills
    cur_tag = "R6";
    for (int i = 0; i < 150; i++) drive(1, (i % 16) == 0, 1, 0);
    // R5: once 192 bits are in, 12 ones per window is a violation
    cur_tag = "R5";
    for (int i = 150; i < 200; i++) drive(1, (i % 16) == 0, 1, 0);

    // R7: clear while still violating: set wins
    cur_tag = "R7";
    drive(1, 1, 1, 1);
    for (int i = 0; i < WIN; i++) drive(1, 1, 1, 0);
    drive(1, 1, 1, 1);  // clean window now: clears
    drive(1, 1, 1, 0);

    // R4: 15 zeros with idle gaps carrying ones, no fault
    cur_tag = "R4";
    for (int i = 0; i < 15; i++) begin
      drive(1, 0, 1, 0);
      if (i % 4 == 1) drive(0, 1, 1, 0);
    end
    drive(1, 1, 1, 0);
    // R3: 16 zeros, violation on the 16th
    cur_tag = "R3";
    for (int i = 0; i < 16; i++) begin
      drive(1, 0, 1, 0);
      if (i == 7) drive(0, 1, 1, 0);
    end
    drive(1, 0, 1, 1);  // R7: longer run, set beats clear
    drive(1, 1, 1, 1);  // one ends the run, clear succeeds
    drive(0, 0, 1, 0);

    // R8: irq gated by the enable
    cur_tag = "R8";
    for (int i = 0; i < 17; i++) drive(1, 0, 0, 0);
    drive(0, 0, 0, 0);
    drive(0, 0, 1, 0);
    drive(0, 0, 0, 0);
    drive(1, 1, 1, 1);

    // R5: periodic block with exactly 23 ones (max run 15): no fault
    cur_tag = "R5";
    for (int i = 0; i < WIN; i++) drive(1, 1, 1, 0);
    for (int r = 0; r < 3; r++)
      for (int i = 0; i < WIN; i++) drive(1, (i % 8 == 0) && i != 96, 1, 0);
    // 22 ones per block: window rule alone fires
    for (int r = 0; r < 2; r++)
      for (int i = 0; i < WIN; i++) drive(1, (i % 8 == 0) && i != 96 && i != 40, 1, 0);
    drive(0, 0, 1, 0);

    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule